// File: doc/BRIEF.md
# Shift Register with JK Entry Stage

This block is a parameterized synchronous register with two operating modes. An active-low mode input picks the mode. In shift mode, each rising clock edge moves every stage one place toward the highest index. The first stage takes its next value from a J input and an active-low K input. With those two inputs the first stage can be forced to 1, forced to 0, inverted, or left as it is.

In load mode, every stage takes the matching bit of a parallel input bus on the rising edge, and J and K have no effect. The outputs are the full stage vector and a separate pin that always carries the inverse of the last stage. An active-low reset clears all stages at once, without waiting for the clock, and overrides every other input.

The block is used for serial-to-parallel capture, parallel-to-serial conversion, and small counter or sequence generators. For counters, the inverted last-stage pin is fed back into J and K. The control pins are plain levels sampled at the clock edge. There is no handshake and no back-pressure, because the register acts on every edge.

Top module: `jk_shift_reg`

## Requirements
- R1: With `load_n` high, a rising edge moves `q_out[i]` into `q_out[i+1]` for every i from 0 to WIDTH-2.
- R2: With `load_n` high, the new `q_out[0]` is `(j_in & ~q0) | (k_n_in & q0)`, where q0 is its value before the edge. The four input cases are: j=1,k_n=1 sets the stage to 1; j=0,k_n=0 clears it to 0; j=1,k_n=0 inverts it; j=0,k_n=1 leaves it unchanged.
- R3: With `load_n` low, a rising edge copies `par_in` into `q_out` bit for bit, and `j_in` and `k_n_in` have no effect on the result.
- R4: Driving `rst_n` low clears `q_out` to all zeros at once, even between clock edges.
- R5: While `rst_n` is low, clock edges have no effect. `q_out` reads 0 and `q_last_n` reads 1, whatever the other inputs are.
- R6: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`.
- R7: With `j_in` tied to `k_n_in` in shift mode, `q_out[0]` takes the value of `j_in`.
- R8: `rst_n` may be released at any time. The first rising edge after release performs the operation that the inputs select at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Low selects parallel load; high selects shift |
| j_in | input | 1 | Serial entry J input of the first stage |
| k_n_in | input | 1 | Serial entry K input of the first stage, active low |
| par_in | input | WIDTH | Parallel load data |
| q_out | output | WIDTH | Stage values, index 0 is the entry stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
The bench builds the block with the default WIDTH of 4, which gives only 16 register states. That small size allows a full sweep: every starting value is combined with every J/K combination across several shifts, and all 16 load patterns are tried with each J/K combination to show that J and K are ignored during a load. The expected state is computed arithmetically in the bench by a shift and a bitwise formula. The reset cases assert `rst_n` in the middle of a clock phase, hold it across an edge, and release it just before an edge.

// File: rtl/jksr_pkg.sv
package jksr_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_SHIFT = 1'b1
  } op_e;

  // Next value of the entry stage: J acts when the stage is 0, active-low K when it is 1.
  function automatic logic jk_next(input logic j, input logic k_n, input logic cur);
    return (j & ~cur) | (k_n & cur);
  endfunction

endpackage

// File: rtl/jksr_entry_stage.sv
module jksr_entry_stage (
  input  logic cur_i,
  input  logic j_i,
  input  logic k_n_i,
  output logic nxt_o
);
  always_comb begin
    nxt_o = jksr_pkg::jk_next(j_i, k_n_i, cur_i);
  end
endmodule

// File: rtl/jksr_next_state.sv
module jksr_next_state #(
  parameter int WIDTH = 4
) (
  input  jksr_pkg::op_e    op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             entry_i,
  output logic [WIDTH-1:0] nxt_o
);
  // Each stage chooses between its parallel bit and its shift source.
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    logic shift_src;
    if (g == 0) begin : g_first
      assign shift_src = entry_i;
    end else begin : g_rest
      assign shift_src = cur_i[g-1];
    end
    assign nxt_o[g] = (op_i == jksr_pkg::OP_SHIFT) ? shift_src : par_i[g];
  end
endmodule

// File: rtl/jksr_stage_regs.sv
module jksr_stage_regs #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             j_in,
  input  logic             k_n_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out,
  output logic             q_last_n
);
  localparam int LAST = WIDTH - 1;

  jksr_pkg::op_e    op;
  logic             entry_nxt;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  assign op = load_n ? jksr_pkg::OP_SHIFT : jksr_pkg::OP_LOAD;

  jksr_entry_stage u_entry (
    .cur_i (state_q[0]),
    .j_i   (j_in),
    .k_n_i (k_n_in),
    .nxt_o (entry_nxt)
  );

  jksr_next_state #(.WIDTH(WIDTH)) u_next (
    .op_i    (op),
    .cur_i   (state_q),
    .par_i   (par_in),
    .entry_i (entry_nxt),
    .nxt_o   (state_d)
  );

  jksr_stage_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  assign q_out    = state_q;
  assign q_last_n = ~state_q[LAST];
endmodule

// File: rtl/jksr_checker.sv
module jksr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             j_in,
  input logic             k_n_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q_out,
  input logic             q_last_n
);
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0])); // R1

  AST_ENTRY_JK: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> q_out[0] == (($past(j_in) & ~$past(q_out[0])) | ($past(k_n_in) & $past(q_out[0])))); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q_out == $past(par_in)); // R3

  AST_RESET_HOLDS: assert property (@(posedge clk)
    !rst_n |-> (q_out == '0) && q_last_n); // R5

  AST_LAST_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    q_last_n == ~q_out[WIDTH-1]); // R6
endmodule

bind jk_shift_reg jksr_checker #(.WIDTH(WIDTH)) u_jksr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_n   (load_n),
  .j_in     (j_in),
  .k_n_in   (k_n_in),
  .par_in   (par_in),
  .q_out    (q_out),
  .q_last_n (q_last_n)
);

// File: tb/tb_jk_shift_reg.sv
module tb_jk_shift_reg;
  localparam int WIDTH      = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NSTATES    = 1 << WIDTH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_n = 1'b0;
  logic             j_in = 1'b0;
  logic             k_n_in = 1'b0;
  logic [WIDTH-1:0] par_in = '0;
  logic [WIDTH-1:0] q_out;
  logic             q_last_n;

  int unsigned      n_checks = 0;
  int unsigned      n_fails  = 0;
  logic [WIDTH-1:0] model = '0;

  jk_shift_reg #(.WIDTH(WIDTH)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .j_in     (j_in),
    .k_n_in   (k_n_in),
    .par_in   (par_in),
    .q_out    (q_out),
    .q_last_n (q_last_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (q_out !== exp || q_last_n !== ~exp[WIDTH-1]) begin
      n_fails++;
      $display("FAIL %s: q_out=%b q_last_n=%b expected q_out=%b q_last_n=%b",
               req, q_out, q_last_n, exp, ~exp[WIDTH-1]);
    end
  endtask

  // Inputs are driven at the falling edge; the result is sampled at the next falling edge.
  task automatic step(input logic ld_n, input logic j, input logic kn,
                      input logic [WIDTH-1:0] p, input string req);
    logic e;
    load_n = ld_n; j_in = j; k_n_in = kn; par_in = p;
    @(posedge clk);
    if (rst_n) begin
      if (!ld_n) model = p;
      else begin
        e = model[0] ? kn : j;
        model = {model[WIDTH-2:0], e};
      end
    end
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R5 reset state", '0);
    rst_n = 1'b1;

    // R1 R2: every start value, every J/K pair, several shifts (expected computed arithmetically)
    for (int s = 0; s < NSTATES; s++) begin
      for (int jk = 0; jk < 4; jk++) begin
        step(1'b0, 1'b0, 1'b0, WIDTH'(s), "R3 load seed");
        for (int n = 0; n < 3; n++)
          step(1'b1, jk[1], jk[0], WIDTH'(~s), "R1 R2 R6 shift with jk");
      end
    end

    // R3: loads of every pattern with every J/K pair; J/K must not matter
    for (int p = 0; p < NSTATES; p++)
      for (int jk = 0; jk < 4; jk++)
        step(1'b0, jk[1], jk[0], WIDTH'(p), "R3 load ignores jk");

    // R7: J tied to K behaves as a D input; run a pattern through
    for (int b = 0; b < 8; b++) begin
      step(1'b1, b[0] ^ b[2], b[0] ^ b[2], '0, "R7 tied jk as D");
      n_checks++;
      if (q_out[0] !== (b[0] ^ b[2])) begin
        n_fails++;
        $display("FAIL R7: q_out[0]=%b expected %b", q_out[0], b[0] ^ b[2]);
      end
    end

    // R4: reset asserted mid-phase clears at once
    step(1'b0, 1'b0, 1'b0, '1, "R3 load ones");
    @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    model = '0;
    check("R4 asynchronous clear mid-cycle", '0);

    // R5: edges during reset have no effect
    step(1'b0, 1'b1, 1'b1, 4'b1010, "R5 load blocked during reset");
    step(1'b1, 1'b1, 1'b1, 4'b1010, "R5 shift blocked during reset");

    // R8: release shortly before an edge; that edge loads
    load_n = 1'b0; par_in = 4'b1001;
    @(posedge clk);
    #(CLK_PERIOD/4);
    @(negedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    @(posedge clk);
    model = 4'b1001;
    @(negedge clk);
    check("R8 first edge after release loads", model);
    step(1'b1, 1'b1, 1'b0, '0, "R8 R2 toggle after release");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule